// File: doc/BRIEF.md
# Motion and Freefall Event Detector

This block watches a stream of signed three-axis acceleration samples and raises a latched interrupt when a configured event occurs. A single mode bit selects the combining rule. In motion mode, an event fires on any sample where at least one enabled axis goes beyond a threshold. In freefall mode, an event fires only after every enabled axis has stayed under the threshold for a programmable run of consecutive samples. Each axis value can first be taken as-is, negated, or reduced to its magnitude. The comparison works on the raw 8-bit sample at a fixed full scale, with no range scaling.

A routing bit sends the event to one of two interrupt lines. Each line is a latch that stays high until its own clear bit is written to 1. The latch cannot set again while that clear bit stays at 1. Software programs the block through a simple write-enable/address port and reads registers back through a registered read port. One of those registers mirrors the two latches.

Top module: `accel_event_det`

## Requirements
- R1: After a synchronous reset, both interrupt outputs are 0 and every register reads back as 0.
- R2: In motion mode (control bit 1 = 0), a valid sample raises the routed interrupt two clock edges after it is taken if the compare value of any enabled axis is strictly greater than the threshold (address 1, unsigned 8 bits). A value equal to the threshold does not raise it.
- R3: Control bit 0 routes events to interrupt output 1 when it is 0 and to interrupt output 2 when it is 1. The other output is left untouched.
- R4: In freefall mode (control bit 1 = 1), with latency L (address 2), the event fires on the (L+1)th consecutive valid sample in which every enabled axis is strictly below the threshold. Exceeding samples never fire it.
- R5: A freefall sample in which any enabled axis is equal to or above the threshold restarts the consecutive-sample count from zero.
- R6: With latency 0 in freefall mode, one qualifying sample raises the interrupt.
- R7: If the window register (address 3) is nonzero, freefall detection never fires.
- R8: A set interrupt output stays high through any later samples until its clear bit is 1. The clear register is address 4: bit 0 clears output 1 and bit 1 clears output 2.
- R9: While a clear bit is 1, its output stays 0 even when events occur. After the bit returns to 0, the next event sets the output again.
- R10: Control bits 6:5 select the compare value. 0 uses the sample itself, 1 uses the negated sample, and 2 or 3 use the magnitude.
- R11: Enable bits (control bit 2 = x, bit 3 = y, bit 4 = z) select the axes. Disabled axes take part in neither rule. With no axis enabled, no event ever occurs.
- R12: The status register (address 5) returns output 1 in bit 0 and output 2 in bit 1, one edge after a read request. Reading it does not change the latches.
- R13: A sample of -128 has magnitude 128 in magnitude mode, so it exceeds a threshold of 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | DATA_W | Signed x-axis sample |
| smp_y | input | DATA_W | Signed y-axis sample |
| smp_z | input | DATA_W | Signed z-axis sample |
| irq1 | output | 1 | Latched interrupt output 1 |
| irq2 | output | 1 | Latched interrupt output 2 |

## Verification
Motion mode is driven with values below, equal to, and above the threshold, which shows the comparison is strict. Spikes are placed on disabled axes and then on enabled ones, which shows the enable mask applies to the OR rule. Freefall mode gets quiet runs one sample short of the latency and then exactly long enough. A further run is broken by a sample sitting exactly on the threshold, which separates a restarting count from one that only pauses. Negative and positive spikes are swapped under each compare mode, and -128 is applied against a threshold of 127. Together these distinguish sign handling and the magnitude edge case.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int AXES = 3;
  localparam int IRQS = 2;

  localparam int A_CTRL = 0;
  localparam int A_THR  = 1;
  localparam int A_LAT  = 2;
  localparam int A_WIN  = 3;
  localparam int A_CLR  = 4;
  localparam int A_STAT = 5;

  typedef enum logic [1:0] {
    CMP_POS  = 2'd0,
    CMP_NEG  = 2'd1,
    CMP_ABS  = 2'd2,
    CMP_ABS2 = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    cmp_mode_e        cmp_mode;
    logic [AXES-1:0]  axis_en;
    logic             freefall;
    logic             pin_sel;
  } ctrl_t;
endpackage

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [IRQS-1:0]   irq_stat,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] thr,
  output logic [DATA_W-1:0] lat,
  output logic [DATA_W-1:0] win,
  output logic [IRQS-1:0]   clr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] ctrl_q, thr_q, lat_q, win_q, clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      lat_q  <= '0;
      win_q  <= '0;
      clr_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(A_CTRL): ctrl_q <= wr_data;
        ADDR_W'(A_THR):  thr_q  <= wr_data;
        ADDR_W'(A_LAT):  lat_q  <= wr_data;
        ADDR_W'(A_WIN):  win_q  <= wr_data;
        ADDR_W'(A_CLR):  clr_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        ADDR_W'(A_CTRL): rd_data <= ctrl_q;
        ADDR_W'(A_THR):  rd_data <= thr_q;
        ADDR_W'(A_LAT):  rd_data <= lat_q;
        ADDR_W'(A_WIN):  rd_data <= win_q;
        ADDR_W'(A_CLR):  rd_data <= clr_q;
        ADDR_W'(A_STAT): rd_data <= DATA_W'(irq_stat);
        default:         rd_data <= '0;
      endcase
    end
  end

  assign ctrl = ctrl_t'(ctrl_q[CTRL_W-1:0]);
  assign thr  = thr_q;
  assign lat  = lat_q;
  assign win  = win_q;
  assign clr  = clr_q[IRQS-1:0];
endmodule

// File: rtl/evt_axis_cmp.sv
module evt_axis_cmp
  import evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] sample,
  input  cmp_mode_e                mode,
  input  logic [DATA_W-1:0]        thr,
  output logic                     over_q,
  output logic                     under_q
);
  localparam int EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0] ext, mag, thr_ext;

  always_comb begin
    ext     = EXT_W'(sample);
    thr_ext = signed'({1'b0, thr});
    case (mode)
      CMP_POS: mag = ext;
      CMP_NEG: mag = -ext;
      default: mag = (ext < 0) ? -ext : ext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      over_q  <= (mag > thr_ext);
      under_q <= (mag < thr_ext);
    end
  end
endmodule

// File: rtl/evt_detect.sv
module evt_detect
  import evt_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [AXES-1:0]  over,
  input  logic [AXES-1:0]  under,
  input  logic [AXES-1:0]  axis_en,
  input  logic             freefall,
  input  logic [LAT_W-1:0] lat,
  input  logic [LAT_W-1:0] win,
  output logic             evt
);
  logic [LAT_W-1:0] run_cnt;
  logic             armed, quiet, loud;

  always_comb begin
    armed = freefall && (win == '0);
    loud  = |(over & axis_en);
    quiet = (axis_en != '0) && (&(under | ~axis_en));
    if (!vld)
      evt = 1'b0;
    else if (!freefall)
      evt = loud;
    else
      evt = armed && quiet && (run_cnt >= lat);
  end

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      run_cnt <= '0;
    end else if (vld) begin
      if (!quiet)
        run_cnt <= '0;
      else if (run_cnt != '1)
        run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evt_latch.sv
module evt_latch
  import evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            evt,
  input  logic            pin_sel,
  input  logic [IRQS-1:0] clr,
  output logic [IRQS-1:0] irq_q
);
  for (genvar i = 0; i < IRQS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || clr[i])
        irq_q[i] <= 1'b0;
      else if (evt && (pin_sel == 1'(i)))
        irq_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/accel_event_det.sv
module accel_event_det
  import evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_x,
  input  logic [DATA_W-1:0] smp_y,
  input  logic [DATA_W-1:0] smp_z,
  output logic              irq1,
  output logic              irq2
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] thr, lat, win;
  logic [IRQS-1:0]   clr_q, irq_q;
  logic [AXES-1:0]   over, under;
  logic              vld_q, evt;
  logic [DATA_W-1:0] axis_smp [AXES];

  assign axis_smp[0] = smp_x;
  assign axis_smp[1] = smp_y;
  assign axis_smp[2] = smp_z;

  evt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .irq_stat(irq_q),
    .ctrl(ctrl), .thr(thr), .lat(lat), .win(win), .clr(clr_q),
    .rd_data(rd_data)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    evt_axis_cmp #(.DATA_W(DATA_W)) u_cmp (
      .clk(clk), .rst(rst),
      .sample(signed'(axis_smp[a])),
      .mode(ctrl.cmp_mode), .thr(thr),
      .over_q(over[a]), .under_q(under[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= smp_valid;
  end

  evt_detect #(.LAT_W(DATA_W)) u_det (
    .clk(clk), .rst(rst), .vld(vld_q),
    .over(over), .under(under), .axis_en(ctrl.axis_en),
    .freefall(ctrl.freefall), .lat(lat), .win(win),
    .evt(evt)
  );

  evt_latch u_latch (
    .clk(clk), .rst(rst), .evt(evt),
    .pin_sel(ctrl.pin_sel), .clr(clr_q), .irq_q(irq_q)
  );

  assign irq1 = irq_q[0];
  assign irq2 = irq_q[1];
endmodule

// File: rtl/evt_checker.sv
module evt_checker
  import evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq1,
  input logic              irq2,
  input logic [IRQS-1:0]   clr,
  input logic              pin_sel,
  input logic [AXES-1:0]   axis_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  // R8
  irq1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq1 && !clr[0]) |=> irq1);
  // R8
  irq2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq2 && !clr[1]) |=> irq2);
  // R9
  clr1_block_chk: assert property (@(posedge clk) disable iff (rst)
    clr[0] |=> !irq1);
  // R9
  clr2_block_chk: assert property (@(posedge clk) disable iff (rst)
    clr[1] |=> !irq2);
  // R3
  pin_route_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq2) |-> $past(pin_sel));
  // R11
  no_axis_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq1) |-> ($past(axis_en) != '0));
  // R12
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(A_STAT)) |=> (rd_data[1:0] == $past({irq2, irq1})));
endmodule

bind accel_event_det evt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .irq1(irq1), .irq2(irq2), .clr(clr_q),
  .pin_sel(ctrl.pin_sel), .axis_en(ctrl.axis_en),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_accel_event_det.sv
`timescale 1ns/1ps
module tb_accel_event_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       wr_en = 0, rd_en = 0, smp_valid = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, smp_x = 0, smp_y = 0, smp_z = 0;
  logic [7:0] rd_data;
  logic       irq1, irq2;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  accel_event_det dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .irq1(irq1), .irq2(irq2)
  );

  // behavioural reference model
  int m_reg [8];
  int m_rd, m_cnt;
  bit m_vld, m_i1, m_i2;
  bit m_ov [3];
  bit m_un [3];

  function automatic int mag(int s, int mode);
    if (mode == 0) return s;
    if (mode == 1) return -s;
    return (s < 0) ? -s : s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_rd = 0; m_cnt = 0; m_vld = 0; m_i1 = 0; m_i2 = 0;
      foreach (m_ov[i]) begin m_ov[i] = 0; m_un[i] = 0; end
    end else begin
      int ctl, en, mode, thr, lat, win, smp[3];
      bit ff, pin, act, quiet, loud, ev;
      ctl = m_reg[0]; thr = m_reg[1]; lat = m_reg[2]; win = m_reg[3];
      pin = ctl[0]; ff = ctl[1]; en = (ctl >> 2) & 7; mode = (ctl >> 5) & 3;
      if (rd_en) m_rd = (rd_addr == 5) ? (int'(m_i2) * 2 + int'(m_i1)) :
                        (rd_addr < 5) ? m_reg[rd_addr] : 0;
      loud = 0; quiet = (en != 0);
      for (int a = 0; a < 3; a++) if (en[a]) begin
        if (m_ov[a]) loud = 1;
        if (!m_un[a]) quiet = 0;
      end
      act = ff && (win == 0);
      ev = m_vld && (!ff ? loud : (act && quiet && m_cnt >= lat));
      if (!act) m_cnt = 0;
      else if (m_vld) m_cnt = quiet ? ((m_cnt < 255) ? m_cnt + 1 : 255) : 0;
      if (m_reg[4][0]) m_i1 = 0; else if (ev && !pin) m_i1 = 1;
      if (m_reg[4][1]) m_i2 = 0; else if (ev && pin) m_i2 = 1;
      smp[0] = int'(signed'(smp_x)); smp[1] = int'(signed'(smp_y)); smp[2] = int'(signed'(smp_z));
      for (int a = 0; a < 3; a++) begin
        m_ov[a] = mag(smp[a], mode) > thr;
        m_un[a] = mag(smp[a], mode) < thr;
      end
      m_vld = smp_valid;
      if (wr_en && wr_addr < 5) m_reg[wr_addr] = int'(wr_data);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (!rst && !done) begin
    tests++;
    if (irq1 !== m_i1 || irq2 !== m_i2) begin
      fails++;
      $display("FAIL R8 model irq got %b%b exp %b%b at %0t", irq2, irq1, m_i2, m_i1, $time);
    end
    tests++;
    if (rd_data !== 8'(m_rd)) begin
      fails++;
      $display("FAIL R12 model rd_data got %0h exp %0h at %0t", rd_data, m_rd, $time);
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic irqs(string tag, bit e1, bit e2);
    chk(tag, {irq2, irq1}, {e2, e1});
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    rd_en = 1; rd_addr = 3'(a);
    @(negedge clk);
    rd_en = 0;
    d = int'(rd_data);
  endtask

  task automatic smp(int x, int y, int z);
    smp_valid = 1; smp_x = 8'(x); smp_y = 8'(y); smp_z = 8'(z);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(4, 3); idle(1); wr(4, 0);
  endtask

  function automatic int ctl(int mode, int en, int ff, int pin);
    return (mode << 5) | (en << 2) | (ff << 1) | pin;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);
    irqs("R1 reset irq", 0, 0);
    rd(5, d); chk("R1 reset status", d, 0);
    rd(0, d); chk("R1 reset ctrl", d, 0);

    // motion, x only, magnitude mode
    wr(0, ctl(2, 1, 0, 0)); wr(1, 40);
    smp(30, 0, 0); idle(2); irqs("R2 below", 0, 0);
    smp(40, 0, 0); idle(2); irqs("R2 equal", 0, 0);
    smp(41, 0, 0); idle(2); irqs("R2 exceed", 1, 0);
    rd(5, d); chk("R12 status read 1", d, 1);
    rd(5, d); chk("R12 status read 2", d, 1);
    irqs("R12 no side effect", 1, 0);

    smp(0, 0, 0); smp(0, 0, 0); idle(2); irqs("R8 hold", 1, 0);
    wr(4, 1); idle(1); irqs("R8 cleared", 0, 0);
    smp(100, 0, 0); idle(2); irqs("R9 clear held", 0, 0);
    wr(4, 0);
    smp(100, 0, 0); idle(2); irqs("R9 rearmed", 1, 0);
    clear_all(); idle(1); irqs("R8 clear", 0, 0);

    // pin routing
    wr(0, ctl(2, 1, 0, 1));
    smp(100, 0, 0); idle(2); irqs("R3 route 2", 0, 1);
    wr(4, 2); idle(1); irqs("R8 clear 2", 0, 0); wr(4, 0);

    // enables
    wr(0, ctl(2, 1, 0, 0));
    smp(0, 120, -120); idle(2); irqs("R11 disabled axes", 0, 0);
    wr(0, ctl(2, 0, 0, 0));
    smp(120, 120, 120); idle(2); irqs("R11 none enabled", 0, 0);
    wr(0, ctl(2, 2, 0, 0));
    smp(0, -41, 0); idle(2); irqs("R2 y axis OR", 1, 0);
    clear_all();

    // compare modes
    wr(0, ctl(0, 1, 0, 0));
    smp(-100, 0, 0); idle(2); irqs("R10 pos ignores neg", 0, 0);
    smp(41, 0, 0); idle(2); irqs("R10 pos", 1, 0);
    clear_all();
    wr(0, ctl(1, 1, 0, 0));
    smp(100, 0, 0); idle(2); irqs("R10 neg ignores pos", 0, 0);
    smp(-41, 0, 0); idle(2); irqs("R10 neg", 1, 0);
    clear_all();

    // full-scale edge
    wr(0, ctl(3, 1, 0, 0)); wr(1, 127);
    smp(127, 0, 0); idle(2); irqs("R13 127", 0, 0);
    smp(-128, 0, 0); idle(2); irqs("R13 -128", 1, 0);
    clear_all();

    // freefall, latency 3
    wr(1, 20); wr(2, 3); wr(3, 0); wr(0, ctl(2, 7, 1, 0));
    smp(50, 50, 50); idle(2); irqs("R4 exceed no fire", 0, 0);
    smp(5, -5, 0); smp(5, -5, 0); smp(5, -5, 0); idle(2);
    irqs("R4 three quiet", 0, 0);
    smp(5, -5, 0); idle(2); irqs("R4 fourth quiet", 1, 0);
    clear_all();

    // break on equal
    smp(50, 0, 0);
    smp(1, 1, 1); smp(1, 1, 1); smp(0, 20, 0);
    smp(1, 1, 1); smp(1, 1, 1); smp(1, 1, 1); idle(2);
    irqs("R5 restart", 0, 0);
    smp(1, 1, 1); idle(2); irqs("R5 after restart", 1, 0);
    clear_all();

    // latency zero
    wr(2, 0);
    smp(50, 0, 0); idle(2); irqs("R6 loud", 0, 0);
    smp(1, 1, 1); idle(2); irqs("R6 single", 1, 0);
    clear_all();

    // window nonzero
    wr(3, 5);
    smp(50, 0, 0); smp(1, 1, 1); smp(1, 1, 1); smp(1, 1, 1); idle(2);
    irqs("R7 disarmed", 0, 0);
    wr(3, 0);

    // freefall with disabled axes
    wr(0, ctl(2, 1, 1, 0));
    smp(5, 100, 100); idle(2); irqs("R11 AND ignores", 1, 0);
    clear_all();
    wr(0, ctl(2, 0, 1, 0));
    smp(1, 1, 1); smp(1, 1, 1); idle(2); irqs("R11 AND none", 0, 0);

    idle(3);
    finish_run();
  end
endmodule